// File: doc/BRIEF.md
# Clocked Serial Channel with Double-Buffered Transmit

This block is one synchronous serial channel for a microcontroller peripheral set. A CPU talks to it through four 8-bit registers: a data buffer, a control/status register, a mode register and a baud register. On the line side it has a transmit line, a receive line and a serial clock. The serial clock is either generated inside the block or taken from an external master. Each byte is eight bits, sent and received most significant bit first. Transmission and reception are full duplex. A byte is received only while a byte is being sent, so the CPU writes a dummy byte to clock data in.

Transmission is double-buffered. A CPU write goes into a holding register. If the shift register is idle, the byte moves over on the next clock cycle. If the shift register is busy, the held byte loads on the rising serial clock edge that ends the current byte, so consecutive bytes leave with no gap.

The first data bit appears on the transmit line before the first clock edge. Later bits change on falling edges, and the receive line is sampled on rising edges. The idle serial clock is high. A one-cycle strobe marks each hand-over from the holding register to the shift register, and another marks each completed received byte.

Top module: `sync_serial_chan`

## Requirements
- R1: After reset the status register (address 1) reads 0x80: bit 7 "transmit buffer empty" set, all other bits clear. The data, mode and baud registers read 0. txd, sclk_out and sclk_oe are high, and both strobes are low.
- R2: A write to the data register (address 0) in an idle channel with mode 0 sets tx_irq for exactly the one cycle after the write edge. On the following edge the byte enters the shift register and status bit 4 (busy) sets. Status bit 7 reads 1 again afterwards.
- R3: The MSB of a loaded byte is on txd before the first falling sclk edge. Bits leave MSB first, and txd changes only on falling edges or when a new byte loads.
- R4: With the internal clock, each sclk half-period lasts H = (baud[3:0] + 1) << baud[5:4] clock cycles. The first falling edge comes H cycles after the load. sclk stays high whenever the channel is not busy.
- R5: A byte written while another is shifting loads on the eighth rising edge of the current byte. The next falling edge follows after exactly H cycles, and both bytes arrive intact.
- R6: rxd is sampled on rising sclk edges, MSB first. rx_irq is high in the cycle that ends with the eighth rising edge. The byte then reads from address 0, status bit 5 (receive full) sets, and reading the data register clears bit 5.
- R7: A byte that completes while bit 5 is still set overwrites the stored byte and sets status bit 6 (overrun). Reading the status register clears bit 6.
- R8: With control bit 0 set (external clock), sclk_oe is low. Shifting follows sclk_in edges seen through a synchronizer, using the same edge rules as R3 and R6. sclk_in edges seen while idle have no effect.
- R9: Mode register bits 1:0 must be 0 for the channel to shift. With any other value a written byte stays held: status bit 7 stays 0 and sclk stays high. The byte starts as soon as the mode returns to 0.
- R10: The mode (address 2, bits 1:0) and baud (address 3, bits 5:0) registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 control/status, 2 mode, 3 baud |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears read-sensitive flags) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| sclk_out | output | 1 | Internally generated serial clock, idle high |
| sclk_oe | output | 1 | High when sclk_out should drive the clock pin |
| sclk_in | input | 1 | External serial clock |
| txd | output | 1 | Transmit data |
| rxd | input | 1 | Receive data |
| rx_irq | output | 1 | One-cycle strobe: received byte complete |
| tx_irq | output | 1 | One-cycle strobe: holding register moved into the shift register |

## Verification
tx_irq is due in the cycle right after the write edge, and the loaded MSB on txd one edge later. The bench samples both at the falling clock edges that follow. With the internal clock, every sclk transition is timed against the expected H cycles from the baud setting, counted at falling clock edges. The first interval is measured from the load edge. Each rising edge captures the txd value seen half a cycle earlier, so a byte that reloads on that same edge is still read correctly. rxd is changed only after a falling sclk is seen. With the external clock the bench holds each sclk_in level for eight cycles, which leaves room for the synchronizer delay of about three cycles before txd and rxd are read.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    localparam int DATA_W      = 8;
    localparam int DIV_W       = 4;
    localparam int PS_W        = 2;
    localparam int SYNC_STAGES = 2;
    // counter wide enough for the longest half period
    localparam int CNT_W       = DIV_W + (1 << PS_W) - 1;

    typedef logic [CNT_W:0] half_t;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_MODE = 2'd2,
        REG_BAUD = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic       tx_empty;
        logic       overrun;
        logic       rx_full;
        logic       busy;
        logic [2:0] rsvd;
        logic       ext_clk;
    } status_t;

    // half period length minus one, in system clock cycles
    function automatic half_t half_minus1(input logic [DIV_W-1:0] div,
                                          input logic [PS_W-1:0]  ps);
        half_t h;
        h = half_t'(div) + half_t'(1);
        return (h << ps) - half_t'(1);
    endfunction

endpackage

// File: rtl/ssc_baud_gen.sv
module ssc_baud_gen
    import ssc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    input  logic [PS_W-1:0]  ps,
    output logic             sclk,
    output logic             fall_ev,
    output logic             rise_ev
);
    logic [CNT_W-1:0] cnt;
    half_t            limit;
    logic             terminal;

    assign limit    = half_minus1(div, ps);
    assign terminal = ({1'b0, cnt} == limit);
    assign fall_ev  = run && terminal && sclk;
    assign rise_ev  = run && terminal && !sclk;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            sclk <= 1'b1;
        end else if (terminal) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ssc_edge_sync.sv
module ssc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic rise_ev,
    output logic fall_ev
);
    logic [STAGES:0] chain;
    logic            last;

    assign chain[0] = pin;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i+1] <= 1'b1;
            else     chain[i+1] <= chain[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b1;
        else     last <= chain[STAGES];
    end

    assign rise_ev = chain[STAGES] && !last;
    assign fall_ev = !chain[STAGES] && last;
endmodule

// File: rtl/ssc_shifter.sv
module ssc_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         hold_full,
    input  logic [W-1:0] hold_data,
    input  logic         rise,
    input  logic         fall,
    input  logic         rxd,
    output logic         busy,
    output logic         txd,
    output logic         load,
    output logic         rx_done,
    output logic [W-1:0] rx_byte
);
    localparam int BW = $clog2(W);
    localparam logic [BW-1:0] LAST_BIT = BW'(W - 1);

    logic [W-1:0]  tx_sh;
    logic [W-2:0]  rx_sh;
    logic [BW-1:0] bcnt;
    logic          last_rise;

    assign last_rise = busy && rise && (bcnt == LAST_BIT);
    assign load      = hold_full && enable && (!busy || last_rise);
    assign rx_done   = last_rise;
    assign rx_byte   = {rx_sh, rxd};
    assign txd       = tx_sh[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh <= '1;
            rx_sh <= '0;
            bcnt  <= '0;
            busy  <= 1'b0;
        end else begin
            if (busy && rise) rx_sh <= {rx_sh[W-3:0], rxd};
            if (load) begin
                tx_sh <= hold_data;
                busy  <= 1'b1;
                bcnt  <= '0;
            end else if (last_rise) begin
                tx_sh <= '1;
                busy  <= 1'b0;
                bcnt  <= '0;
            end else begin
                if (busy && rise) bcnt <= bcnt + BW'(1);
                // first falling edge of a byte keeps the pre-driven MSB
                if (busy && fall && bcnt != '0) tx_sh <= {tx_sh[W-2:0], 1'b1};
            end
        end
    end

    // R3
    txd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !fall && !last_rise) |=> $stable(txd));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (last_rise && hold_full && enable) |=> busy);
endmodule

// File: rtl/sync_serial_chan.sv
module sync_serial_chan
    import ssc_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       sclk_out,
    output logic       sclk_oe,
    input  logic       sclk_in,
    output logic       txd,
    input  logic       rxd,
    output logic       rx_irq,
    output logic       tx_irq
);
    localparam int W = DATA_W;

    reg_sel_e sel;
    logic [W-1:0] hold_q, rx_q, rx_byte;
    logic hold_full, rx_full, ovr, ext_q;
    logic [1:0] mode_q;
    logic [DIV_W+PS_W-1:0] baud_q;
    logic busy, load, rx_done;
    logic i_rise, i_fall, x_rise, x_fall, rise, fall;
    logic wr_data, rd_data, rd_stat;
    status_t st;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_data = bus_wr && sel == REG_DATA;
    assign rd_data = bus_rd && sel == REG_DATA;
    assign rd_stat = bus_rd && sel == REG_CTRL;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0; rx_q <= '0;
            hold_full <= 1'b0; rx_full <= 1'b0; ovr <= 1'b0;
            ext_q <= 1'b0; mode_q <= '0; baud_q <= '0;
        end else begin
            if (load)    hold_full <= 1'b0;
            if (wr_data) begin
                hold_q    <= bus_wdata;
                hold_full <= 1'b1;
            end
            if (rd_data) rx_full <= 1'b0;
            if (rd_stat) ovr     <= 1'b0;
            if (rx_done) begin
                rx_q    <= rx_byte;
                rx_full <= 1'b1;
                if (rx_full && !rd_data) ovr <= 1'b1;
            end
            if (bus_wr && sel == REG_CTRL) ext_q  <= bus_wdata[0];
            if (bus_wr && sel == REG_MODE) mode_q <= bus_wdata[1:0];
            if (bus_wr && sel == REG_BAUD) baud_q <= bus_wdata[DIV_W+PS_W-1:0];
        end
    end

    always_comb begin
        st = '{tx_empty: !hold_full, overrun: ovr, rx_full: rx_full,
               busy: busy, rsvd: 3'b000, ext_clk: ext_q};
        case (sel)
            REG_DATA: bus_rdata = rx_q;
            REG_CTRL: bus_rdata = st;
            REG_MODE: bus_rdata = {6'b0, mode_q};
            default:  bus_rdata = {{(8-DIV_W-PS_W){1'b0}}, baud_q};
        endcase
    end

    ssc_baud_gen u_baud (
        .clk(clk), .rst(rst), .run(busy && !ext_q),
        .div(baud_q[DIV_W-1:0]), .ps(baud_q[DIV_W+PS_W-1:DIV_W]),
        .sclk(sclk_out), .fall_ev(i_fall), .rise_ev(i_rise)
    );

    ssc_edge_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(sclk_in),
        .rise_ev(x_rise), .fall_ev(x_fall)
    );

    assign rise = ext_q ? x_rise : i_rise;
    assign fall = ext_q ? x_fall : i_fall;

    ssc_shifter #(.W(W)) u_shift (
        .clk(clk), .rst(rst), .enable(mode_q == 2'b00),
        .hold_full(hold_full), .hold_data(hold_q),
        .rise(rise), .fall(fall), .rxd(rxd),
        .busy(busy), .txd(txd), .load(load),
        .rx_done(rx_done), .rx_byte(rx_byte)
    );

    assign sclk_oe = !ext_q;
    assign tx_irq  = load;
    assign rx_irq  = rx_done;

    // R2
    tx_load_chk: assert property (@(posedge clk) disable iff (rst)
        tx_irq |=> busy);

    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sclk_out);

    // R6
    rx_full_chk: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> (bus_rdata == rx_q || sel != REG_DATA) && rx_full);

    // R7
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_irq && rx_full && !rd_data) |=> ovr);
endmodule

// File: tb/sim_sync_serial_chan.sv
module sim_sync_serial_chan;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic sclk_out, sclk_oe, txd, rx_irq, tx_irq;
    logic sclk_in = 1'b1;
    logic rxd = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    sync_serial_chan u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sclk_in(sclk_in),
        .txd(txd), .rxd(rxd), .rx_irq(rx_irq), .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Acts as the far end on the internal clock: captures txd as seen just
    // before each rising sclk, drives rxd after each falling sclk, times edges.
    task automatic recv(input int nbits, input logic [15:0] pat, input int exp_h,
                        input bit chk_first, output logic [15:0] got,
                        output int bad, output int irqs);
        int t = 0, last = 0, rises = 0;
        bit seen_fall = 1'b0;
        logic ps, pt;
        got = '0; bad = 0; irqs = 0;
        ps = sclk_out; pt = txd;
        while (rises < nbits) begin
            @(negedge clk);
            t++;
            if (rx_irq) irqs++;
            if (ps && !sclk_out) begin
                if ((seen_fall || chk_first) && (t - last != exp_h)) bad++;
                seen_fall = 1'b1;
                last = t;
                rxd = pat[nbits-1-rises];
            end else if (!ps && sclk_out) begin
                if (t - last != exp_h) bad++;
                last = t;
                got = {got[14:0], pt};
                rises++;
            end
            ps = sclk_out; pt = txd;
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 sclk_out", sclk_out, 1);
        chk("R1 sclk_oe", sclk_oe, 1);
        chk("R1 strobes", {rx_irq, tx_irq}, 0);
        rd_reg(2'd1, d); chk("R1 status", d, 8'h80);
        rd_reg(2'd0, d); chk("R1 data", d, 0);
        rd_reg(2'd2, d); chk("R1 mode", d, 0);
        rd_reg(2'd3, d); chk("R1 baud", d, 0);
    endtask

    task automatic t_regs;
        logic [7:0] d;
        wr_reg(2'd2, 8'hFE); rd_reg(2'd2, d); chk("R10 mode readback", d, 8'h02);
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd3, 8'hDB); rd_reg(2'd3, d); chk("R10 baud readback", d, 8'h1B);
    endtask

    task automatic t_single(input logic [7:0] baud, input int h,
                            input logic [7:0] tx, input logic [7:0] rx);
        logic [15:0] got; int bad, irqs; logic [7:0] d;
        wr_reg(2'd3, baud);
        wr_reg(2'd0, tx);
        chk("R2 tx_irq after write", tx_irq, 1);
        @(negedge clk);
        chk("R2 tx_irq one cycle", tx_irq, 0);
        chk("R3 MSB before first edge", txd, tx[7]);
        chk("R4 sclk high at load", sclk_out, 1);
        recv(8, {8'h00, rx}, h, 1'b1, got, bad, irqs);
        chk("R3 tx bits msb first", got[7:0], tx);
        chk("R4 half period timing", bad, 0);
        chk("R6 rx_irq count", irqs, 1);
        rd_reg(2'd1, d); chk("R2 status after byte", d, 8'hA0);
        rd_reg(2'd0, d); chk("R6 rx data", d, rx);
        rd_reg(2'd1, d); chk("R6 rx_full cleared", d, 8'h80);
    endtask

    task automatic t_back2back;
        logic [15:0] got; int bad, irqs; logic [7:0] d;
        wr_reg(2'd3, 8'h12);                 // H = 3 << 1 = 6
        wr_reg(2'd0, 8'hC3);
        wr_reg(2'd0, 8'h5A);
        rd_reg(2'd1, d); chk("R5 second byte held", d[7], 0);
        recv(16, 16'h1234, 6, 1'b0, got, bad, irqs);
        chk("R5 both bytes", got, 16'hC35A);
        chk("R5 no gap", bad, 0);
        chk("R7 two rx strobes", irqs, 2);
        rd_reg(2'd1, d); chk("R7 overrun set", d, 8'hE0);
        rd_reg(2'd1, d); chk("R7 overrun cleared by status read", d, 8'hA0);
        rd_reg(2'd0, d); chk("R7 newest byte kept", d, 8'h34);
    endtask

    task automatic t_mode_hold;
        logic [15:0] got; int bad, irqs; logic [7:0] d; int moved = 0;
        wr_reg(2'd3, 8'h00);
        wr_reg(2'd2, 8'h03);
        wr_reg(2'd0, 8'h96);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!sclk_out || tx_irq) moved++;
        end
        chk("R9 no shifting in mode 3", moved, 0);
        rd_reg(2'd1, d); chk("R9 byte still held", d, 8'h00);
        wr_reg(2'd2, 8'h00);
        chk("R9 starts when mode 0", tx_irq, 1);
        @(negedge clk);
        recv(8, 16'h0000, 1, 1'b1, got, bad, irqs);
        chk("R9 held byte sent", got[7:0], 8'h96);
        rd_reg(2'd0, d);
    endtask

    task automatic t_external(input logic [7:0] tx, input logic [7:0] rx);
        logic [7:0] got = '0; logic [7:0] d; int moved = 0;
        wr_reg(2'd1, 8'h01);
        chk("R8 sclk_oe low", sclk_oe, 0);
        for (int i = 0; i < 3; i++) begin      // idle edges must do nothing
            sclk_in = 1'b0; repeat (4) @(negedge clk);
            sclk_in = 1'b1; repeat (4) @(negedge clk);
            if (rx_irq) moved++;
        end
        rd_reg(2'd1, d); chk("R8 idle edges ignored", d, 8'h81);
        wr_reg(2'd0, tx);
        repeat (3) @(negedge clk);
        chk("R8 MSB before first edge", txd, tx[7]);
        for (int b = 7; b >= 0; b--) begin
            rxd = rx[b]; sclk_in = 1'b0;
            repeat (8) @(negedge clk);
            got = {got[6:0], txd};
            sclk_in = 1'b1;
            repeat (8) @(negedge clk);
        end
        chk("R8 tx bits", got, tx);
        chk("R8 sclk_out quiet", sclk_out, 1);
        rd_reg(2'd1, d); chk("R8 status", d, 8'hA1);
        rd_reg(2'd0, d); chk("R8 rx data", d, rx);
        chk("R8 no idle strobes", moved, 0);
        wr_reg(2'd1, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset;
        t_regs;
        t_single(8'h00, 1, 8'hA5, 8'h3C);
        t_single(8'h31, 16, 8'h81, 8'hE7);  // H = 2 << 3
        t_back2back;
        t_mode_hold;
        t_external(8'h6D, 8'hB2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule